// File: doc/BRIEF.md
# Windowed Peak Detector for Correlation Scores

This block watches a continuous stream of correlation scores and reduces it to one report per window. The stream is cut into back-to-back windows, each a programmable number of valid samples long. Inside a window the block keeps the strongest score that lies strictly above a programmable threshold. At the window's final sample it emits a one-cycle result carrying a found flag, the winning score and the timestamp supplied with that sample.

The timestamp is a 32-bit sample counter kept outside the block and presented alongside each score. The block copies the value of the winning sample into the result without changing it, so wrapped counter values pass through unaltered. Threshold and window length are taken at the first sample of each window and held until that window closes. Scores are compared as unsigned by default, and a parameter selects two's-complement comparison instead.

Top module: `peak_window_detector`

## Requirements
- R1: While reset is held and after it is released, out_strobe, out_found, out_peak and out_stamp are all 0 until the first window closes.
- R2: A window spans exactly the latched length in valid samples. Cycles with in_valid low neither advance the window nor alter any state. out_strobe is high for exactly the one cycle that follows the clock edge on which the window's last valid sample is taken.
- R3: When a window holds at least one qualifying score, out_found is 1 and out_peak is the largest qualifying score in the window.
- R4: A score qualifies only if it is strictly greater than the window's threshold. A score equal to the threshold never counts.
- R5: When several samples share the maximum qualifying score, out_stamp is the in_stamp value of the earliest of them.
- R6: When no score in a window qualifies, the result shows out_found = 0, out_peak = 0 and out_stamp = 0.
- R7: cfg_threshold and cfg_win_len are sampled together with the first valid sample of a window. Changes made while a window is open have no effect until the next window begins.
- R8: A window length of 0 is treated as 1, so every valid sample forms its own window and produces its own result.
- R9: out_stamp is the exact 32-bit in_stamp value that accompanied the peak sample, including values near and after wrap-around.
- R10: out_found, out_peak and out_stamp keep their values between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Score sample strobe |
| in_score | input | SCORE_W | Correlation score |
| in_stamp | input | TS_W | Sample counter value for this score |
| cfg_threshold | input | SCORE_W | Qualification threshold (strict) |
| cfg_win_len | input | LEN_W | Window length in valid samples, 0 means 1 |
| out_strobe | output | 1 | One-cycle result strobe |
| out_found | output | 1 | A qualifying peak was seen in the window |
| out_peak | output | SCORE_W | Peak score, 0 when none |
| out_stamp | output | TS_W | Timestamp of the peak, 0 when none |

## Verification
A corrupted window counter shows up as a strobe one or more valid samples away from the expected boundary, and it does so at the very next window end. A stale or uncleared running maximum carries into the following window, which produces a wrong peak or a false found flag at that window's strobe. A wrong tie-break or a wrong threshold comparison changes the reported timestamp or the found flag in the same window where it occurs, so each fault appears at most one window length after its cause.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
   typedef enum logic {
      CMP_UNSIGNED = 1'b0,
      CMP_SIGNED   = 1'b1
   } cmp_mode_e;
endpackage

// File: rtl/pwd_window_ctrl.sv
module pwd_window_ctrl #(
   parameter int SCORE_W = 16,
   parameter int LEN_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_valid,
   input  logic [LEN_W-1:0]   cfg_len,
   input  logic [SCORE_W-1:0] cfg_thr,
   output logic               win_last,
   output logic [SCORE_W-1:0] eff_thr
);
   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

   logic               open_q;
   logic [LEN_W-1:0]   cnt_q;
   logic [LEN_W-1:0]   len_q;
   logic [SCORE_W-1:0] thr_q;

   logic [LEN_W-1:0]   len_in;
   logic [LEN_W-1:0]   eff_len;
   logic [LEN_W-1:0]   cnt_cur;

   // zero length folds onto one sample per window
   assign len_in  = (cfg_len == '0) ? LEN_ONE : cfg_len;
   assign eff_len = open_q ? len_q : len_in;
   assign eff_thr = open_q ? thr_q : cfg_thr;
   assign cnt_cur = open_q ? cnt_q : '0;
   assign win_last = smp_valid && (cnt_cur == eff_len - LEN_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
         len_q  <= LEN_ONE;
         thr_q  <= '0;
      end else if (smp_valid) begin
         if (!open_q) begin
            len_q <= len_in;
            thr_q <= cfg_thr;
         end
         if (win_last) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            open_q <= 1'b1;
            cnt_q  <= cnt_cur + LEN_ONE;
         end
      end
   end

   assert_cnt_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      open_q |-> (cnt_q < len_q));

   assert_len_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      open_q |-> (len_q != '0));

   assert_cfg_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && !$past(win_last) && $past(open_q)) |-> ($stable(len_q) && $stable(thr_q)));
endmodule

// File: rtl/pwd_peak_track.sv
module pwd_peak_track #(
   parameter int                SCORE_W  = 16,
   parameter int                TS_W     = 32,
   parameter pwd_pkg::cmp_mode_e CMP_MODE = pwd_pkg::CMP_UNSIGNED
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_valid,
   input  logic [SCORE_W-1:0] score,
   input  logic [TS_W-1:0]    stamp,
   input  logic [SCORE_W-1:0] thr,
   input  logic               win_last,
   output logic               cand_found,
   output logic [SCORE_W-1:0] cand_peak,
   output logic [TS_W-1:0]    cand_stamp
);
   logic               have_q;
   logic [SCORE_W-1:0] best_q;
   logic [TS_W-1:0]    stamp_q;
   logic               above;
   logic               beats;
   logic               take;

   generate
      if (CMP_MODE == pwd_pkg::CMP_SIGNED) begin : g_signed
         assign above = $signed(score) > $signed(thr);
         assign beats = $signed(score) > $signed(best_q);
      end else begin : g_unsigned
         assign above = score > thr;
         assign beats = score > best_q;
      end
   endgenerate

   // strict beat keeps the earliest of equal maxima
   assign take       = smp_valid && above && (!have_q || beats);
   assign cand_found = have_q || take;
   assign cand_peak  = take ? score : (have_q ? best_q : '0);
   assign cand_stamp = take ? stamp : (have_q ? stamp_q : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_q  <= 1'b0;
         best_q  <= '0;
         stamp_q <= '0;
      end else if (smp_valid) begin
         if (win_last) begin
            have_q  <= 1'b0;
            best_q  <= '0;
            stamp_q <= '0;
         end else begin
            have_q  <= cand_found;
            best_q  <= cand_peak;
            stamp_q <= cand_stamp;
         end
      end
   end

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(smp_valid) |-> ($stable(have_q) && $stable(best_q) && $stable(stamp_q)));

   assert_tie_keeps_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(have_q) && !$past(win_last) && $past(smp_valid) && ($past(score) == $past(best_q)))
      |-> $stable(stamp_q));
endmodule

// File: rtl/pwd_result_reg.sv
module pwd_result_reg #(
   parameter int                 SCORE_W  = 16,
   parameter int                 TS_W     = 32,
   parameter pwd_pkg::cmp_mode_e CMP_MODE = pwd_pkg::CMP_UNSIGNED
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               cand_found,
   input  logic [SCORE_W-1:0] cand_peak,
   input  logic [TS_W-1:0]    cand_stamp,
   input  logic [SCORE_W-1:0] win_thr,
   output logic               res_strobe,
   output logic               res_found,
   output logic [SCORE_W-1:0] res_peak,
   output logic [TS_W-1:0]    res_stamp
);
   localparam bit IS_SIGNED = (CMP_MODE == pwd_pkg::CMP_SIGNED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_strobe <= 1'b0;
         res_found  <= 1'b0;
         res_peak   <= '0;
         res_stamp  <= '0;
      end else begin
         res_strobe <= load;
         if (load) begin
            res_found <= cand_found;
            res_peak  <= cand_peak;
            res_stamp <= cand_stamp;
         end
      end
   end

   assert_found_above_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_strobe && res_found) |->
         (IS_SIGNED ? ($signed(res_peak) > $signed($past(win_thr))) : (res_peak > $past(win_thr))));

   assert_empty_is_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_strobe && !res_found) |-> (res_peak == '0 && res_stamp == '0));

   assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !res_strobe |-> ($stable(res_found) && $stable(res_peak) && $stable(res_stamp)));
endmodule

// File: rtl/peak_window_detector.sv
module peak_window_detector #(
   parameter int                 SCORE_W  = 16,
   parameter int                 LEN_W    = 8,
   parameter int                 TS_W     = 32,
   parameter pwd_pkg::cmp_mode_e CMP_MODE = pwd_pkg::CMP_UNSIGNED
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [SCORE_W-1:0] in_score,
   input  logic [TS_W-1:0]    in_stamp,
   input  logic [SCORE_W-1:0] cfg_threshold,
   input  logic [LEN_W-1:0]   cfg_win_len,
   output logic               out_strobe,
   output logic               out_found,
   output logic [SCORE_W-1:0] out_peak,
   output logic [TS_W-1:0]    out_stamp
);
   generate
      if (SCORE_W < 2) begin : g_bad_score_w
         $error("peak_window_detector: SCORE_W must be at least 2");
      end
      if (LEN_W < 1 || LEN_W > 24) begin : g_bad_len_w
         $error("peak_window_detector: LEN_W must lie in 1..24");
      end
      if (TS_W < 1) begin : g_bad_ts_w
         $error("peak_window_detector: TS_W must be at least 1");
      end
   endgenerate

   logic               win_last;
   logic [SCORE_W-1:0] win_thr;
   logic               cand_found;
   logic [SCORE_W-1:0] cand_peak;
   logic [TS_W-1:0]    cand_stamp;

   pwd_window_ctrl #(
      .SCORE_W(SCORE_W),
      .LEN_W  (LEN_W)
   ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_valid(in_valid),
      .cfg_len  (cfg_win_len),
      .cfg_thr  (cfg_threshold),
      .win_last (win_last),
      .eff_thr  (win_thr)
   );

   pwd_peak_track #(
      .SCORE_W (SCORE_W),
      .TS_W    (TS_W),
      .CMP_MODE(CMP_MODE)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (in_valid),
      .score     (in_score),
      .stamp     (in_stamp),
      .thr       (win_thr),
      .win_last  (win_last),
      .cand_found(cand_found),
      .cand_peak (cand_peak),
      .cand_stamp(cand_stamp)
   );

   pwd_result_reg #(
      .SCORE_W (SCORE_W),
      .TS_W    (TS_W),
      .CMP_MODE(CMP_MODE)
   ) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (win_last),
      .cand_found(cand_found),
      .cand_peak (cand_peak),
      .cand_stamp(cand_stamp),
      .win_thr   (win_thr),
      .res_strobe(out_strobe),
      .res_found (out_found),
      .res_peak  (out_peak),
      .res_stamp (out_stamp)
   );

   assert_strobe_follows_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_strobe |-> $past(in_valid));
endmodule

// File: tb/peak_window_detector_tb_top.sv
`timescale 1ns/1ps
module peak_window_detector_tb_top;
   localparam int SW = 16;
   localparam int LW = 8;
   localparam int TW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [SW-1:0] in_score = '0;
   logic [TW-1:0] in_stamp = '0;
   logic [SW-1:0] cfg_threshold = '0;
   logic [LW-1:0] cfg_win_len = '0;
   logic          out_strobe;
   logic          out_found;
   logic [SW-1:0] out_peak;
   logic [TW-1:0] out_stamp;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference state
   bit          m_open = 0;
   int          m_cnt = 0;
   int          m_len = 1;
   logic [SW-1:0] m_thr = '0;
   bit          m_have = 0;
   logic [SW-1:0] m_best = '0;
   logic [TW-1:0] m_time = '0;
   logic [TW-1:0] ts = '0;
   bit          e_found = 0;
   logic [SW-1:0] e_peak = '0;
   logic [TW-1:0] e_stamp = '0;

   always #10 clk = ~clk;

   peak_window_detector #(.SCORE_W(SW), .LEN_W(LW), .TS_W(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_score(in_score),
      .in_stamp(in_stamp), .cfg_threshold(cfg_threshold), .cfg_win_len(cfg_win_len),
      .out_strobe(out_strobe), .out_found(out_found), .out_peak(out_peak),
      .out_stamp(out_stamp)
   );

   function automatic int eff_len(input logic [LW-1:0] l);
      return (l == 0) ? 1 : int'(l);
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input bit v, input logic [SW-1:0] s,
                       input logic [SW-1:0] th, input logic [LW-1:0] ln, input string req);
      bit exp_strobe = 0;
      @(negedge clk);
      in_valid = v; in_score = s; cfg_threshold = th; cfg_win_len = ln; in_stamp = ts;
      if (v) begin
         if (!m_open) begin
            m_len = eff_len(ln); m_thr = th; m_cnt = 0; m_have = 0;
         end
         if (s > m_thr && (!m_have || s > m_best)) begin
            m_have = 1; m_best = s; m_time = ts;
         end
         if (m_cnt == m_len - 1) begin
            exp_strobe = 1;
            e_found = m_have;
            e_peak  = m_have ? m_best : '0;
            e_stamp = m_have ? m_time : '0;
            m_open = 0; m_have = 0;
         end else begin
            m_cnt++; m_open = 1;
         end
         ts = ts + 1;
      end
      @(posedge clk);
      #1;
      check({req, " strobe"}, longint'(out_strobe), longint'(exp_strobe));
      if (exp_strobe || out_strobe) begin
         check({req, " found"}, longint'(out_found), longint'(e_found));
         check({req, " peak"},  longint'(out_peak),  longint'(e_peak));
         check({req, " stamp"}, longint'(out_stamp), longint'(e_stamp));
      end else begin
         check("R10 hold", longint'({out_found, out_peak, out_stamp}),
               longint'({e_found, e_peak, e_stamp}));
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 strobe", longint'(out_strobe), 0);
      check("R1 found",  longint'(out_found), 0);
      check("R1 peak",   longint'(out_peak), 0);
      check("R1 stamp",  longint'(out_stamp), 0);
      rst_n = 1'b1;
      step(0, 0, 0, 4, "R1 idle");

      // R4 / R6: equal to threshold and below never qualify
      step(1, 50, 50, 4, "R4");
      step(1, 10, 50, 4, "R4");
      step(1, 50, 50, 4, "R4");
      step(1, 49, 50, 4, "R6");

      // R3 / R5: ties keep earliest stamp
      step(1, 20, 10, 5, "R3");
      step(1, 30, 10, 5, "R5");
      step(1, 30, 10, 5, "R5");
      step(1, 5,  10, 5, "R5");
      step(1, 30, 10, 5, "R5");

      // R2: gaps of invalid cycles inside a window
      step(1, 70, 0, 3, "R2");
      step(0, 999, 0, 3, "R2");
      step(0, 999, 0, 3, "R2");
      step(1, 80, 0, 3, "R2");
      step(0, 999, 0, 3, "R2");
      step(1, 60, 0, 3, "R2");

      // R7: mid-window config changes ignored
      step(1, 40, 35, 4, "R7");
      step(1, 30, 100, 1, "R7");
      step(1, 36, 100, 1, "R7");
      step(1, 10, 0, 9, "R7");
      step(1, 10, 0, 2, "R7");

      // R8: zero length gives one-sample windows
      step(1, 7, 3, 0, "R8");
      step(1, 2, 3, 0, "R8");
      step(1, 9, 3, 0, "R8");

      // R9: timestamp wrap
      ts = 32'hFFFF_FFFD;
      for (int i = 0; i < 6; i++) step(1, SW'(i == 4 ? 500 : 100 + i), 50, 6, "R9");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic [LW-1:0] l;
         l = LW'($urandom_range(0, 12));
         step(($urandom_range(0, 3) != 0), SW'($urandom_range(0, 300)),
              SW'($urandom_range(100, 200)), l, "R3 random");
      end
      step(0, 0, 0, 1, "R2 tail");
      finish_run();
   end
endmodule